// File: doc/BRIEF.md
# Random Generator Status and Interrupt Register

This block keeps the status word of a random number generator as a simple bus sees it. It records when a fresh random word waits to be collected and shows two live fault conditions: a seed fault from the noise checks and a clock fault from the clock-speed monitor. For each fault it also keeps a sticky copy that stays set after the fault has gone. Software clears a sticky copy by writing zero to its bit.

A single interrupt request is driven from these flags through an interrupt-enable input. The data path, the noise source and the fault detectors are outside the block. They reach it only as pulses and levels: a word-produced pulse, a data-read pulse, and the two fault levels. A control input turns off the clock-fault check. All inputs are registered, so the status word shows each event one clock after it is presented.

Top module: `rng_status_reg`

## Requirements
- R1: `status` is 32 bits. Bit 0 is data ready, bit 1 is the live clock fault, bit 2 is the live seed fault, bit 5 is the sticky clock fault and bit 6 is the sticky seed fault. Every other bit always reads 0.
- R2: A sticky fault bit becomes 1 on the same clock edge on which its live bit goes from 0 to 1.
- R3: A write (`wr_en` high) with 0 in bit 5 or bit 6 of `wr_data` clears that sticky bit on the next edge. A 1 in that position leaves it unchanged.
- R4: A `word_ready` pulse sets data ready on the next edge. A `data_read` pulse clears it on the next edge, and it stays 0 until another `word_ready`. When both arrive in the same cycle, data ready ends at 1.
- R5: `irq` is 1 exactly when `irq_en` is 1 and at least one of data ready, sticky clock fault or sticky seed fault is 1.
- R6: While `clk_chk_dis` is 1, the live clock fault bit is 0 after the next edge, whatever `clk_err_live` is. A sticky clock fault cannot be raised during that time.
- R7: Writes do not change data ready or the live fault bits.
- R8: If a sticky bit is written with 0 in the same cycle that its live fault rises, the sticky bit ends at 1.
- R9: Reset (`rst_n` low) sets every status bit and `irq` to 0.
- R10: The live fault bits show the fault inputs one cycle later. A sticky bit stays 1 after its live bit returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_ready | input | 1 | Pulse: a new random word has been produced |
| data_read | input | 1 | Pulse: the data word was read by the bus |
| seed_err_live | input | 1 | Level from the noise-quality check |
| clk_err_live | input | 1 | Level from the clock-speed monitor |
| clk_chk_dis | input | 1 | 1 turns off the clock-fault check |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Bus write strobe for the status word |
| wr_data | input | 32 | Bus write data |
| status | output | 32 | Status word read value |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cases where set and clear compete in one cycle. These are a read and a new word arriving together, and a write of zero landing on the edge where a fault rises. A design that lets the clear win in either case would lose a word or a fault. The bench writes all ones over set sticky bits, which catches a design that toggles or clears on a one. It also writes zeros over data ready and the live bits, which catches a status word that accepts writes to read-only bits. Finally, it holds a sticky bit after its fault has cleared and turns the clock check off while a clock fault is present. A design that made the sticky bit follow the level, or ignored the disable, would show the wrong bit.

// File: rtl/rng_status_reg.sv
module rng_status_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_ready,
  input  logic         data_read,
  input  logic         seed_err_live,
  input  logic         clk_err_live,
  input  logic         clk_chk_dis,
  input  logic         irq_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] status,
  output logic         irq
);
  localparam int B_RDY  = 0;
  localparam int B_CLK  = 1;
  localparam int B_SEED = 2;
  localparam int B_SCLK = 5;
  localparam int B_SSEED = 6;

  logic rdy, clk_f, seed_f, clk_s, seed_s;
  logic clk_in, clk_rise, seed_rise, clr_clk, clr_seed;
  logic unused_wr;

  assign clk_in    = clk_err_live & ~clk_chk_dis;
  assign clk_rise  = clk_in & ~clk_f;
  assign seed_rise = seed_err_live & ~seed_f;
  assign clr_clk   = wr_en & ~wr_data[B_SCLK];
  assign clr_seed  = wr_en & ~wr_data[B_SSEED];
  assign unused_wr = ^{wr_data[W-1:B_SSEED+1], wr_data[B_SCLK-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy    <= 1'b0;
      clk_f  <= 1'b0;
      seed_f <= 1'b0;
      clk_s  <= 1'b0;
      seed_s <= 1'b0;
    end else begin
      if (word_ready)     rdy <= 1'b1;
      else if (data_read) rdy <= 1'b0;
      clk_f  <= clk_in;
      seed_f <= seed_err_live;
      clk_s  <= clk_rise  | (clk_s  & ~clr_clk);
      seed_s <= seed_rise | (seed_s & ~clr_seed);
    end
  end

  always_comb begin
    status          = '0;
    status[B_RDY]   = rdy;
    status[B_CLK]   = clk_f;
    status[B_SEED]  = seed_f;
    status[B_SCLK]  = clk_s;
    status[B_SSEED] = seed_s;
  end

  assign irq = irq_en & (rdy | clk_s | seed_s);
endmodule

// File: rtl/rng_status_reg_chk.sv
module rng_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_ready,
  input logic        data_read,
  input logic        seed_err_live,
  input logic        clk_err_live,
  input logic        clk_chk_dis,
  input logic        irq_en,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] status,
  input logic        irq
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status[31:7] == '0 && status[4:3] == '0);
  assert_sticky_with_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> status[6]);
  assert_clear_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[6] && !(seed_err_live && !status[2]) |=> !status[6]);
  assert_w1_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[5] && status[5] |=> status[5]);
  assert_ready_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |=> status[0]);
  assert_ready_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_read && !word_ready |=> !status[0]);
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  assert_irq_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en && status[0] |-> irq);
  assert_clk_dis_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_chk_dis |=> !status[1]);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_err_live && !status[2] |=> status[6]);
  assert_live_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seed_err_live |=> status[2]);
  assert_live_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_err_live |=> !status[2]);
endmodule

bind rng_status_reg rng_status_reg_chk u_chk (.*);

// File: tb/rng_status_reg_bench.sv
module rng_status_reg_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic word_ready = 0, data_read = 0, seed_err_live = 0, clk_err_live = 0;
  logic clk_chk_dis = 0, irq_en = 0, wr_en = 0;
  logic [31:0] wr_data = '0, status;
  logic irq;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  rng_status_reg u_rng_status_reg (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    word_ready = 0; data_read = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R9 status", status, 32'h0);
    chk("R9 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ready();
    word_ready = 1; step();
    chk("R4 set", status, 32'h1);
    step();
    chk("R4 hold", status, 32'h1);
    data_read = 1; step();
    chk("R4 clear", status, 32'h0);
    step();
    chk("R4 stays 0", status, 32'h0);
    word_ready = 1; step();
    word_ready = 1; data_read = 1; step();
    chk("R4 both", status, 32'h1);
    data_read = 1; step();
  endtask

  task automatic t_seed();
    seed_err_live = 1; step();
    chk("R2 R10 seed rise", status, 32'h44);
    seed_err_live = 0; step();
    chk("R10 sticky kept", status, 32'h40);
    wr_en = 1; wr_data = 32'hFFFF_FFFF; step();
    chk("R3 w1 ignored", status, 32'h40);
    wr_en = 1; wr_data = 32'hFFFF_FFBF; step();
    chk("R3 w0 clears", status, 32'h0);
  endtask

  task automatic t_clk();
    clk_err_live = 1; step();
    chk("R2 clk rise", status, 32'h22);
    clk_chk_dis = 1; step();
    chk("R6 forced 0", status, 32'h20);
    wr_en = 1; wr_data = 32'h0; step();
    chk("R6 no resticky", status, 32'h0);
    step();
    chk("R6 still 0", status, 32'h0);
    clk_chk_dis = 0; step();
    chk("R6 reenable", status, 32'h22);
    clk_err_live = 0; wr_en = 1; wr_data = 32'h0; step();
    chk("R3 clk cleared", status, 32'h0);
  endtask

  task automatic t_ro();
    word_ready = 1; seed_err_live = 1; clk_err_live = 1; step();
    wr_en = 1; wr_data = 32'h0; step();
    chk("R7 ro bits kept", status, 32'h7);
    wr_en = 1; wr_data = 32'hFFFF_FFFF; step();
    chk("R7 R1 write ones", status, 32'h7);
    seed_err_live = 0; clk_err_live = 0; data_read = 1; step();
    chk("R7 cleanup", status, 32'h0);
  endtask

  task automatic t_set_wins();
    seed_err_live = 1; wr_en = 1; wr_data = 32'h0; step();
    chk("R8 seed set wins", status, 32'h44);
    seed_err_live = 0; wr_en = 1; wr_data = 32'h0; step();
    chk("R8 later clear", status, 32'h0);
  endtask

  task automatic t_irq();
    irq_en = 0; word_ready = 1; step();
    chk("R5 masked", {31'b0, irq}, 32'h0);
    irq_en = 1; #1;
    chk("R5 ready irq", {31'b0, irq}, 32'h1);
    data_read = 1; step();
    chk("R5 no source", {31'b0, irq}, 32'h0);
    clk_err_live = 1; step();
    clk_err_live = 0; step();
    chk("R5 sticky irq", {31'b0, irq}, 32'h1);
    wr_en = 1; wr_data = 32'h0; step();
    chk("R5 cleared", {31'b0, irq}, 32'h0);
    irq_en = 0;
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #12;
    t_reset();
    @(negedge clk); rst_n = 1;
    step();
    t_ready();
    t_seed();
    t_clk();
    t_ro();
    t_set_wins();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule